// File: doc/BRIEF.md
# Two-Port Ownership Flag Bank

This block holds a small bank of ownership flags that two independent ports share. Two agents use them to coordinate access to a common resource, such as a region of a dual-port memory. Each port has an active-low select, a write strobe, an address and a data path. While the select is low, the port's cycle reaches the flag bank. While it is high, the cycle belongs to the memory next door and the bank ignores it.

A port asks for a flag by writing a 0 in data bit 0. It then reads the flag to learn whether it was granted: the read returns all zeros if that port holds the flag and all ones if it does not. It gives the flag up by writing a 1. A request made while the other side holds the flag is remembered, and the flag passes to the waiting side one cycle after the holder lets go. When both ports ask for the same free flag in the same cycle, the left port gets it and the right port waits.

The design runs on one clock with a synchronous, active-high reset.

Top module: `dual_sema_unit`

## Requirements
- R1: Reset (synchronous, active high) leaves every flag unowned with no waiting request, so every read from either port returns 8'hFF. A reset applied while requests are waiting discards them.
- R2: A write with select low and data bit 0 equal to 0 on a free flag, with no request already waiting, makes the writing port the holder at the next clock edge. From then on, reads from that port return 8'h00 and reads from the other port return 8'hFF.
- R3: Only address bits [2:0] choose one of the eight flags. Higher address bits are ignored, and an access to one flag leaves the others unchanged.
- R4: Only data bit 0 of a write matters: 0 requests and 1 releases. Bits [7:1] are ignored.
- R5: While a port's select is high, its writes change no flag, and its read data is 8'hFF.
- R6: At no time do both ports hold the same flag.
- R7: A release write from the holder frees the flag at the next edge. A release write from the port that does not hold the flag has no effect.
- R8: A request made while the other port holds the flag is recorded as waiting. When the holder releases at edge k, the flag reads free from both ports until edge k+1, and at edge k+1 the waiting port becomes the holder.
- R9: If both ports request the same free flag in the same cycle, the left port becomes the holder and the right port's request waits.
- R10: The two ports may take different flags in the same cycle, and both requests are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sem_n | input | 1 | Left port flag select, active low |
| l_wr | input | 1 | Left port write strobe (0 = read) |
| l_addr | input | ADDR_W | Left port address; bits [2:0] pick the flag |
| l_wdata | input | DATA_W | Left port write data; bit 0 used |
| l_rdata | output | DATA_W | Left port read data: all 0 = held by left, all 1 otherwise |
| r_sem_n | input | 1 | Right port flag select, active low |
| r_wr | input | 1 | Right port write strobe (0 = read) |
| r_addr | input | ADDR_W | Right port address; bits [2:0] pick the flag |
| r_wdata | input | DATA_W | Right port write data; bit 0 used |
| r_rdata | output | DATA_W | Right port read data: all 0 = held by right, all 1 otherwise |

## Verification
Read data is combinational from the registered flag state, so the result of a write presented in one cycle shows up on a read presented in the next cycle. The bench drives each write on a falling edge and the matching read on the following falling edge, and samples shortly after that second edge. A waiting request is granted only one edge after the release, so the bench checks for a free flag in the read that directly follows the release and checks for the new holder one cycle later. After a reset, the bench checks twice, one edge apart, to show that a discarded waiting request is never granted.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   wait_l;
        logic   wait_r;
    } flag_state_t;

endpackage

// File: rtl/sema_port_decode.sv
module sema_port_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    localparam int FLAG_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 sem_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic [FLAG_W-1:0]    idx,
    output logic                 rd_en
);
    logic wr_sel;
    logic unused_bits;

    assign idx         = addr[FLAG_W-1:0];
    assign wr_sel      = !sem_n && wr;
    assign rd_en       = !sem_n && !wr;
    assign unused_bits = ^{addr[ADDR_W-1:FLAG_W], wdata[DATA_W-1:1]};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
        logic hit;
        assign hit        = wr_sel && (idx == FLAG_W'(i));
        assign req_vec[i] = hit && !wdata[0];
        assign rel_vec[i] = hit &&  wdata[0];
    end
endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_l,
    input  logic rel_l,
    input  logic req_r,
    input  logic rel_r,
    output logic own_l,
    output logic own_r,
    output logic wait_l,
    output logic wait_r
);
    flag_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q.owner)
            OWN_NONE: begin
                if (state_q.wait_l) begin
                    state_d.owner  = OWN_LEFT;
                    state_d.wait_l = 1'b0;
                    if (req_r) state_d.wait_r = 1'b1;
                end else if (state_q.wait_r) begin
                    state_d.owner  = OWN_RIGHT;
                    state_d.wait_r = 1'b0;
                    if (req_l) state_d.wait_l = 1'b1;
                end else if (req_l) begin
                    state_d.owner = OWN_LEFT;
                    if (req_r) state_d.wait_r = 1'b1;
                end else if (req_r) begin
                    state_d.owner = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                if (rel_l) state_d.owner  = OWN_NONE;
                if (req_r) state_d.wait_r = 1'b1;
            end
            OWN_RIGHT: begin
                if (rel_r) state_d.owner  = OWN_NONE;
                if (req_l) state_d.wait_l = 1'b1;
            end
            default: state_d.owner = OWN_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{owner: OWN_NONE, wait_l: 1'b0, wait_r: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign own_l  = (state_q.owner == OWN_LEFT);
    assign own_r  = (state_q.owner == OWN_RIGHT);
    assign wait_l = state_q.wait_l;
    assign wait_r = state_q.wait_r;
endmodule

// File: rtl/sema_read_mux.sv
module sema_read_mux #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int FLAG_W   = $clog2(NUM_FLAGS)
) (
    input  logic                 rd_en,
    input  logic [FLAG_W-1:0]    idx,
    input  logic [NUM_FLAGS-1:0] own_vec,
    output logic [DATA_W-1:0]    rdata
);
    always_comb begin
        rdata = {DATA_W{1'b1}};
        if (rd_en && own_vec[idx]) rdata = {DATA_W{1'b0}};
    end
endmodule

// File: rtl/dual_sema_unit.sv
module dual_sema_unit #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sem_n,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sem_n,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int FLAG_W = $clog2(NUM_FLAGS);

    logic [NUM_FLAGS-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_FLAGS-1:0] own_l, own_r, wait_l, wait_r;
    logic [FLAG_W-1:0]    l_idx, r_idx;
    logic                 l_rd, r_rd;

    sema_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sem_n(l_sem_n), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
        .req_vec(l_req), .rel_vec(l_rel), .idx(l_idx), .rd_en(l_rd)
    );

    sema_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sem_n(r_sem_n), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
        .req_vec(r_req), .rel_vec(r_rel), .idx(r_idx), .rd_en(r_rd)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        sema_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .req_l(l_req[i]), .rel_l(l_rel[i]),
            .req_r(r_req[i]), .rel_r(r_rel[i]),
            .own_l(own_l[i]), .own_r(own_r[i]),
            .wait_l(wait_l[i]), .wait_r(wait_r[i])
        );
    end

    sema_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
        .rd_en(l_rd), .idx(l_idx), .own_vec(own_l), .rdata(l_rdata)
    );

    sema_read_mux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
        .rd_en(r_rd), .idx(r_idx), .own_vec(own_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/dual_sema_unit_chk.sv
module dual_sema_unit_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    localparam int FLAG_W   = $clog2(NUM_FLAGS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 l_sem_n,
    input logic                 l_wr,
    input logic [ADDR_W-1:0]    l_addr,
    input logic [DATA_W-1:0]    l_wdata,
    input logic [DATA_W-1:0]    l_rdata,
    input logic                 r_sem_n,
    input logic                 r_wr,
    input logic [ADDR_W-1:0]    r_addr,
    input logic [DATA_W-1:0]    r_wdata,
    input logic [DATA_W-1:0]    r_rdata,
    input logic [NUM_FLAGS-1:0] own_l,
    input logic [NUM_FLAGS-1:0] own_r,
    input logic [NUM_FLAGS-1:0] wait_l,
    input logic [NUM_FLAGS-1:0] wait_r
);
    logic [FLAG_W-1:0] li, ri;
    logic l_req, r_req, l_rel, r_rwr;
    assign li    = l_addr[FLAG_W-1:0];
    assign ri    = r_addr[FLAG_W-1:0];
    assign l_req = !l_sem_n && l_wr && !l_wdata[0];
    assign r_req = !r_sem_n && r_wr && !r_wdata[0];
    assign l_rel = !l_sem_n && l_wr &&  l_wdata[0];
    assign r_rwr = !r_sem_n && r_wr;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (own_l == '0 && own_r == '0 && wait_l == '0 && wait_r == '0));

    assert_read_value_R2: assert property (@(posedge clk) disable iff (rst)
        (!l_sem_n && !l_wr) |-> (l_rdata == (own_l[li] ? {DATA_W{1'b0}} : {DATA_W{1'b1}})));

    assert_deselect_read_R5: assert property (@(posedge clk) disable iff (rst)
        (l_sem_n && r_sem_n) |-> (l_rdata == {DATA_W{1'b1}} && r_rdata == {DATA_W{1'b1}}));

    assert_deselect_write_R5: assert property (@(posedge clk) disable iff (rst)
        (l_sem_n && r_sem_n && wait_l == '0 && wait_r == '0) |=> ($stable(own_l) && $stable(own_r)));

    assert_mutex_R6: assert property (@(posedge clk) disable iff (rst)
        (own_l & own_r) == '0);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag_chk
        logic tie_hit, foreign_rel;
        assign tie_hit = l_req && r_req && li == FLAG_W'(i) && ri == FLAG_W'(i)
                       && !own_l[i] && !own_r[i] && !wait_l[i] && !wait_r[i];
        assign foreign_rel = l_rel && li == FLAG_W'(i) && own_r[i]
                           && !(r_rwr && ri == FLAG_W'(i));

        assert_foreign_release_R7: assert property (@(posedge clk) disable iff (rst)
            foreign_rel |=> own_r[i]);

        assert_handover_l2r_R8: assert property (@(posedge clk) disable iff (rst)
            ($fell(own_l[i]) && wait_r[i]) |=> own_r[i]);

        assert_handover_r2l_R8: assert property (@(posedge clk) disable iff (rst)
            ($fell(own_r[i]) && wait_l[i]) |=> own_l[i]);

        assert_tie_left_R9: assert property (@(posedge clk) disable iff (rst)
            tie_hit |=> (own_l[i] && wait_r[i]));
    end
endmodule

bind dual_sema_unit dual_sema_unit_chk #(
    .NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst(rst),
    .l_sem_n(l_sem_n), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sem_n(r_sem_n), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .own_l(own_l), .own_r(own_r), .wait_l(wait_l), .wait_r(wait_r)
);

// File: tb/dual_sema_unit_tb.sv
`timescale 1ns/1ps
module dual_sema_unit_tb;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam logic [1:0] OP_IDLE = 2'd0;
    localparam logic [1:0] OP_REQ  = 2'd1;
    localparam logic [1:0] OP_REL  = 2'd2;
    localparam logic [1:0] OP_OFF  = 2'd3;
    localparam int VW = 2 + AW + 2 + AW + AW + AW + 2;
    localparam int NV = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sem_n = 1'b1, l_wr = 1'b0, r_sem_n = 1'b1, r_wr = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dual_sema_unit u_dut (
        .clk(clk), .rst(rst),
        .l_sem_n(l_sem_n), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sem_n(r_sem_n), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    function automatic logic [VW-1:0] v(input logic [1:0] lop, input logic [AW-1:0] la,
                                        input logic [1:0] rop, input logic [AW-1:0] ra,
                                        input logic [AW-1:0] rla, input logic [AW-1:0] rra,
                                        input logic el, input logic er);
        return {lop, la, rop, ra, rla, rra, el, er};
    endfunction

    // write phase, then read phase; el/er: expected holder seen by each side
    localparam logic [VW-1:0] VEC [NV] = '{
        v(OP_REQ,  12'h003, OP_IDLE, 12'h000, 12'h003, 12'h003, 1'b1, 1'b0), // R2
        v(OP_IDLE, 12'h000, OP_REQ,  12'h003, 12'h003, 12'h003, 1'b1, 1'b0), // R8 wait
        v(OP_REL,  12'h003, OP_IDLE, 12'h000, 12'h003, 12'h003, 1'b0, 1'b0), // R8 free gap
        v(OP_IDLE, 12'h000, OP_IDLE, 12'h000, 12'h003, 12'h003, 1'b0, 1'b1), // R8 handover
        v(OP_REL,  12'h003, OP_IDLE, 12'h000, 12'h003, 12'h003, 1'b0, 1'b1), // R7 foreign
        v(OP_IDLE, 12'h000, OP_REL,  12'h003, 12'h003, 12'h003, 1'b0, 1'b0), // R7 holder
        v(OP_REQ,  12'h005, OP_REQ,  12'h005, 12'h005, 12'h005, 1'b1, 1'b0), // R9 tie
        v(OP_REL,  12'h005, OP_IDLE, 12'h000, 12'h005, 12'h005, 1'b0, 1'b0), // R9
        v(OP_IDLE, 12'h000, OP_IDLE, 12'h000, 12'h005, 12'h005, 1'b0, 1'b1), // R9 right gets it
        v(OP_IDLE, 12'h000, OP_REL,  12'h005, 12'h005, 12'h005, 1'b0, 1'b0), // R7
        v(OP_REQ,  12'h00A, OP_REQ,  12'hFF6, 12'h002, 12'h006, 1'b1, 1'b1), // R10 R3
        v(OP_IDLE, 12'h000, OP_IDLE, 12'h000, 12'h7F6, 12'h802, 1'b0, 1'b0), // R3 cross
        v(OP_OFF,  12'h006, OP_IDLE, 12'h000, 12'h006, 12'h006, 1'b0, 1'b1), // R5
        v(OP_REL,  12'hA42, OP_IDLE, 12'h000, 12'h002, 12'h002, 1'b0, 1'b0), // R4 R3
        v(OP_IDLE, 12'h000, OP_REL,  12'h006, 12'h006, 12'h006, 1'b0, 1'b0)  // R4
    };
    string row_tag [NV] = '{"R2", "R8", "R8", "R8", "R7", "R7", "R9", "R9", "R9", "R7",
                            "R10", "R3", "R5", "R4", "R4"};

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R4: request data 8'hFE (bit0=0), release data 8'h01 (bit0=1)
    task automatic side(input logic [1:0] op, input logic [AW-1:0] a,
                        output logic sn, output logic w, output logic [AW-1:0] ad,
                        output logic [DW-1:0] wd);
        ad = a;
        unique case (op)
            OP_IDLE: begin sn = 1'b1; w = 1'b0; wd = 8'h00; end
            OP_REQ:  begin sn = 1'b0; w = 1'b1; wd = 8'hFE; end
            OP_REL:  begin sn = 1'b0; w = 1'b1; wd = 8'h01; end
            default: begin sn = 1'b1; w = 1'b1; wd = 8'h00; end
        endcase
    endtask

    task automatic read_both(input logic [AW-1:0] la, input logic [AW-1:0] ra);
        l_sem_n = 1'b0; l_wr = 1'b0; l_addr = la;
        r_sem_n = 1'b0; r_wr = 1'b0; r_addr = ra;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: all flags free after reset
        for (int f = 0; f < 8; f++) begin
            @(negedge clk);
            read_both(AW'(f), AW'(f));
            #1;
            check("R1 left", l_rdata, 8'hFF);
            check("R1 right", r_rdata, 8'hFF);
        end
        // table walk
        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] e;
            e = VEC[k];
            @(negedge clk);
            side(e[VW-1 -: 2], e[VW-3 -: AW], l_sem_n, l_wr, l_addr, l_wdata);
            side(e[VW-3-AW -: 2], e[VW-5-AW -: AW], r_sem_n, r_wr, r_addr, r_wdata);
            @(negedge clk);
            read_both(e[2+AW+AW-1 -: AW], e[2+AW-1 -: AW]);
            #1;
            check(row_tag[k], l_rdata, e[1] ? 8'h00 : 8'hFF);
            check(row_tag[k], r_rdata, e[0] ? 8'h00 : 8'hFF);
        end
        // R5: deselected read shows 8'hFF even for the holder
        @(negedge clk);
        side(OP_REQ, 12'h004, l_sem_n, l_wr, l_addr, l_wdata);
        side(OP_IDLE, 12'h000, r_sem_n, r_wr, r_addr, r_wdata);
        @(negedge clk);
        l_sem_n = 1'b1; l_wr = 1'b0; l_addr = 12'h004;
        #1;
        check("R5 deselected read", l_rdata, 8'hFF);
        l_sem_n = 1'b0;
        #1;
        check("R2 holder read", l_rdata, 8'h00);
        // R1: reset discards a waiting request
        @(negedge clk);
        side(OP_IDLE, 12'h000, l_sem_n, l_wr, l_addr, l_wdata);
        side(OP_REQ, 12'h004, r_sem_n, r_wr, r_addr, r_wdata);
        @(negedge clk);
        side(OP_IDLE, 12'h000, r_sem_n, r_wr, r_addr, r_wdata);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_both(12'h004, 12'h004);
        #1;
        check("R1 left after mid reset", l_rdata, 8'hFF);
        check("R1 right after mid reset", r_rdata, 8'hFF);
        @(negedge clk);
        #1;
        check("R1 waiting request discarded", r_rdata, 8'hFF);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule